// File: doc/BRIEF.md
# Indirect-Access Vectored Interrupt Controller

This block gathers up to 128 interrupt inputs and drives one request line to a processor. Each input has a priority, a trigger type, a vector word and an enable flag. Software does not reach these settings through wide bitmap registers. It first writes a source number into a select pointer. After that, the mode and vector registers and the one-bit enable, disable, clear and set commands act only on that one source.

Among the sources that are both active and enabled, the block picks the one with the highest priority. When two of them share a priority, the lower source number wins. The request goes out only if the winner's priority is strictly above the priority at the top of an 8-level nesting stack. When the processor reads the interrupt vector register, that read acknowledges the winner. The read returns the winner's vector, pushes its priority and number onto the stack, and clears any latched pending bit of that source. A write to the end-of-interrupt register pops the stack. If the processor reads the vector register while nothing qualifies, the read returns a programmable spurious value and the stack does not change.

The register port is a single-cycle 32-bit bus. Read data is combinational in the access cycle, and all side effects happen on the clock edge that ends the access.

Top module: `vic_indirect`

## Requirements
- R1: After reset, every source is disabled and not pending, with priority 0, level-high type and vector 0. The stack is empty, the spurious value is 0, the select pointer is 0 and `irq_req` is low.
- R2: The select register at 0x00 keeps only bits [6:0] of a write and reads them back zero-extended. The mode register (0x04) and the vector register (0x08) read and write only the source named by the pointer.
- R3: The mode register holds the priority in bits [2:0] and the type in bits [6:5]. Bit 5 set means edge-sensitive and bit 6 set means inverted, so 00 is level-high, 01 is rising, 10 is level-low and 11 is falling. Level types follow the input. Edge types latch pending on the chosen transition.
- R4: Writing a 1 in bit 0 to 0x40 enables the selected source, and writing it to 0x44 disables it. A disabled source never causes a request, but its pending state stays visible.
- R5: Writing a 1 in bit 0 to 0x48 clears the selected source's latched pending bit, and writing it to 0x4C sets that bit. Both commands do nothing when bit 0 is 0.
- R6: Offsets 0x20, 0x24, 0x28 and 0x2C read the active state of sources 0-31, 32-63, 64-95 and 96-127, with source n at bit n mod 32. Offset 0x30 returns the enable flag of the selected source in bit 0. Offset 0x34 returns `irq_req` in bit 0.
- R7: Among the active and enabled sources, the highest priority wins. On a tie, the lowest source number wins.
- R8: A read of 0x10 while a request qualifies returns the winner's vector, clears its latched pending bit and pushes its priority and number onto the stack.
- R9: A request qualifies only when the stack is empty or the winner's priority is strictly greater than the priority on top of the stack.
- R10: Offset 0x18 reads 0 while the stack is empty. Otherwise it reads bit 8 set and the top entry's source number in bits [6:0].
- R11: A write to 0x38 pops one stack entry, and a write to it while the stack is empty does nothing. The stack holds 8 entries, and 8 writes to 0x38 always empty it.
- R12: Offset 0x3C holds the spurious value. A read of 0x10 with no qualifying request returns that value and leaves the stack unchanged.
- R13: `irq_req` is registered. It follows a level input change or a register write one clock edge later, and an input edge on an edge-typed source two clock edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_in | input | NSRC | Interrupt inputs, synchronous to clk |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| irq_req | output | 1 | Interrupt request to the processor |

## Verification
Read data is due in the cycle of the access, so the bench samples `bus_rdata` shortly after it drives the address. The acknowledge and the stack update land on the edge that ends that cycle. `irq_req` reacts to a register write or a level input change one edge later, and to an input edge on an edge-typed source two edges later. The bench therefore samples the request at the falling edge after the exact number of rising edges. Where the due edge is the second one, it first checks that the request is still low one edge earlier. After a vector read, the request keeps its old value for one more edge, so the checks that expect it to drop wait one extra falling edge.

// File: rtl/vic_pkg.sv
package vic_pkg;
  // register offsets
  localparam logic [7:0] OFS_SEL   = 8'h00;
  localparam logic [7:0] OFS_MODE  = 8'h04;
  localparam logic [7:0] OFS_VEC   = 8'h08;
  localparam logic [7:0] OFS_IVEC  = 8'h10;
  localparam logic [7:0] OFS_STAT  = 8'h18;
  localparam logic [7:0] OFS_ENA   = 8'h30;
  localparam logic [7:0] OFS_REQ   = 8'h34;
  localparam logic [7:0] OFS_EOI   = 8'h38;
  localparam logic [7:0] OFS_SPUR  = 8'h3C;
  localparam logic [7:0] OFS_EN    = 8'h40;
  localparam logic [7:0] OFS_DIS   = 8'h44;
  localparam logic [7:0] OFS_CLR   = 8'h48;
  localparam logic [7:0] OFS_SET   = 8'h4C;
  localparam logic [3:0] PEND_HI   = 4'h2;
  // mode field layout
  localparam int TRG_LSB   = 5;
  localparam int TRG_EDGE  = 0;
  localparam int TRG_INV   = 1;
  localparam int STAT_VLD  = 8;
endpackage

// File: rtl/vic_src_bank.sv
module vic_src_bank
  import vic_pkg::*;
#(
  parameter int NSRC   = 128,
  parameter int PRIO_W = 3,
  parameter int VEC_W  = 32,
  parameter int SEL_W  = 7
) (
  input  logic                    clk,
  input  logic                    srst_n,
  input  logic [NSRC-1:0]         src_in,
  input  logic [SEL_W-1:0]        sel,
  input  logic                    wr_mode,
  input  logic                    wr_vec,
  input  logic                    cmd_en,
  input  logic                    cmd_dis,
  input  logic                    cmd_clr,
  input  logic                    cmd_set,
  input  logic [31:0]             wdata,
  input  logic                    ack,
  input  logic [SEL_W-1:0]        win_id,
  output logic [NSRC-1:0]         active,
  output logic [NSRC-1:0]         enabled,
  output logic [NSRC*PRIO_W-1:0]  prio_flat,
  output logic [PRIO_W-1:0]       sel_prio,
  output logic [1:0]              sel_trig,
  output logic [VEC_W-1:0]        sel_vec,
  output logic                    sel_en,
  output logic [VEC_W-1:0]        win_vec
);
  logic [NSRC*2-1:0]     trig_flat;
  logic [NSRC*VEC_W-1:0] vec_flat;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    logic              en_r, lat_r, prev_r;
    logic              en_d, lat_d;
    logic [PRIO_W-1:0] prio_r;
    logic [1:0]        trig_r;
    logic [VEC_W-1:0]  vec_r;
    logic              hit, lvl, lvl_prev, edge_det, mode_ce, vec_ce;

    always_comb begin
      hit      = (sel == SEL_W'(g));
      mode_ce  = hit & wr_mode;
      vec_ce   = hit & wr_vec;
      lvl      = src_in[g] ^ trig_r[TRG_INV];
      lvl_prev = prev_r ^ trig_r[TRG_INV];
      edge_det = trig_r[TRG_EDGE] & lvl & ~lvl_prev;
      en_d = en_r;
      if (hit && cmd_en)  en_d = 1'b1;
      if (hit && cmd_dis) en_d = 1'b0;
      // new edge wins over clear or acknowledge in the same cycle
      lat_d = lat_r;
      if (hit && cmd_clr)               lat_d = 1'b0;
      if (ack && (win_id == SEL_W'(g))) lat_d = 1'b0;
      if (hit && cmd_set)               lat_d = 1'b1;
      if (edge_det)                     lat_d = 1'b1;
    end

    always_ff @(posedge clk or negedge srst_n) begin
      if (!srst_n) begin
        en_r   <= 1'b0;
        lat_r  <= 1'b0;
        prev_r <= 1'b0;
        prio_r <= '0;
        trig_r <= '0;
        vec_r  <= '0;
      end else begin
        en_r   <= en_d;
        lat_r  <= lat_d;
        prev_r <= src_in[g];
        if (mode_ce) begin
          prio_r <= wdata[PRIO_W-1:0];
          trig_r <= wdata[TRG_LSB +: 2];
        end
        if (vec_ce) vec_r <= wdata[VEC_W-1:0];
      end
    end

    assign active[g]                       = lat_r | (~trig_r[TRG_EDGE] & lvl);
    assign enabled[g]                      = en_r;
    assign prio_flat[g*PRIO_W +: PRIO_W]   = prio_r;
    assign trig_flat[g*2 +: 2]             = trig_r;
    assign vec_flat[g*VEC_W +: VEC_W]      = vec_r;
  end

  always_comb begin
    sel_prio = '0;
    sel_trig = '0;
    sel_vec  = '0;
    sel_en   = 1'b0;
    win_vec  = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (sel == SEL_W'(i)) begin
        sel_prio = prio_flat[i*PRIO_W +: PRIO_W];
        sel_trig = trig_flat[i*2 +: 2];
        sel_vec  = vec_flat[i*VEC_W +: VEC_W];
        sel_en   = enabled[i];
      end
      if (win_id == SEL_W'(i)) win_vec = vec_flat[i*VEC_W +: VEC_W];
    end
  end
endmodule

// File: rtl/vic_arbiter.sv
module vic_arbiter #(
  parameter int NSRC   = 128,
  parameter int PRIO_W = 3,
  parameter int SEL_W  = 7
) (
  input  logic [NSRC-1:0]        cand,
  input  logic [NSRC*PRIO_W-1:0] prio_flat,
  output logic                   found,
  output logic [SEL_W-1:0]       win_id,
  output logic [PRIO_W-1:0]      win_prio
);
  // strict compare keeps the lowest index on a tie
  always_comb begin
    found    = 1'b0;
    win_id   = '0;
    win_prio = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (cand[i] && (!found || (prio_flat[i*PRIO_W +: PRIO_W] > win_prio))) begin
        found    = 1'b1;
        win_id   = SEL_W'(i);
        win_prio = prio_flat[i*PRIO_W +: PRIO_W];
      end
    end
  end
endmodule

// File: rtl/vic_nest_stack.sv
module vic_nest_stack #(
  parameter int DEPTH  = 8,
  parameter int PRIO_W = 3,
  parameter int SEL_W  = 7,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              srst_n,
  input  logic              push,
  input  logic              pop,
  input  logic [PRIO_W-1:0] push_prio,
  input  logic [SEL_W-1:0]  push_id,
  output logic [PRIO_W-1:0] top_prio,
  output logic [SEL_W-1:0]  top_id,
  output logic [CNT_W-1:0]  level
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [PRIO_W-1:0] prio_m [DEPTH];
  logic [SEL_W-1:0]  id_m   [DEPTH];
  logic [CNT_W-1:0]  lvl_q, lvl_d;
  logic [IDX_W-1:0]  wr_idx, top_idx;
  logic              full, empty, do_push, do_pop;

  always_comb begin
    full    = (lvl_q == CNT_W'(DEPTH));
    empty   = (lvl_q == '0);
    do_push = push & ~full;
    do_pop  = pop & ~empty & ~push;
    lvl_d   = lvl_q;
    if (do_push)     lvl_d = lvl_q + 1'b1;
    else if (do_pop) lvl_d = lvl_q - 1'b1;
    wr_idx  = IDX_W'(lvl_q);
    top_idx = IDX_W'(lvl_q - 1'b1);
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) lvl_q <= '0;
    else         lvl_q <= lvl_d;
  end

  // entries need no reset: they are only read below the fill level
  always_ff @(posedge clk) begin
    if (do_push) begin
      prio_m[wr_idx] <= push_prio;
      id_m[wr_idx]   <= push_id;
    end
  end

  assign top_prio = empty ? '0 : prio_m[top_idx];
  assign top_id   = empty ? '0 : id_m[top_idx];
  assign level    = lvl_q;
endmodule

// File: rtl/vic_indirect.sv
module vic_indirect
  import vic_pkg::*;
#(
  parameter int NSRC       = 128,
  parameter int PRIO_W     = 3,
  parameter int VEC_W      = 32,
  parameter int NEST_DEPTH = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_in,
  input  logic            bus_sel,
  input  logic            bus_wr,
  input  logic [7:0]      bus_addr,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  output logic            irq_req
);
  localparam int SEL_W = (NSRC > 1) ? $clog2(NSRC) : 1;
  localparam int CNT_W = $clog2(NEST_DEPTH + 1);
  localparam int NWORD = (NSRC + 31) / 32;
  localparam int PAD_W = NWORD * 32;

  logic [1:0]             rst_pipe;
  logic                   srst_n;
  logic                   wr, rd;
  logic                   wr_sel, wr_mode, wr_vec, wr_spur;
  logic                   cmd_en, cmd_dis, cmd_clr, cmd_set;
  logic                   ack, eoi, take, found, stk_empty;
  logic [SEL_W-1:0]       sel_q, win_id, top_id;
  logic [PRIO_W-1:0]      win_prio, top_prio, sel_prio;
  logic [1:0]             sel_trig;
  logic [VEC_W-1:0]       spur_q, sel_vec, win_vec;
  logic                   sel_en, irq_q;
  logic [NSRC-1:0]        active, enabled, cand;
  logic [NSRC*PRIO_W-1:0] prio_flat;
  logic [CNT_W-1:0]       stk_level;
  logic [PAD_W-1:0]       pend_pad;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign srst_n = rst_pipe[1];

  always_comb begin
    wr      = bus_sel & bus_wr;
    rd      = bus_sel & ~bus_wr;
    wr_sel  = wr & (bus_addr == OFS_SEL);
    wr_mode = wr & (bus_addr == OFS_MODE);
    wr_vec  = wr & (bus_addr == OFS_VEC);
    wr_spur = wr & (bus_addr == OFS_SPUR);
    cmd_en  = wr & (bus_addr == OFS_EN)  & bus_wdata[0];
    cmd_dis = wr & (bus_addr == OFS_DIS) & bus_wdata[0];
    cmd_clr = wr & (bus_addr == OFS_CLR) & bus_wdata[0];
    cmd_set = wr & (bus_addr == OFS_SET) & bus_wdata[0];
    eoi     = wr & (bus_addr == OFS_EOI);
    cand      = active & enabled;
    stk_empty = (stk_level == '0);
    take      = found & (stk_empty | (win_prio > top_prio));
    ack       = rd & (bus_addr == OFS_IVEC) & take;
    pend_pad  = PAD_W'(active);
  end

  vic_src_bank #(.NSRC(NSRC), .PRIO_W(PRIO_W), .VEC_W(VEC_W), .SEL_W(SEL_W)) u_bank (
    .clk(clk), .srst_n(srst_n), .src_in(src_in), .sel(sel_q),
    .wr_mode(wr_mode), .wr_vec(wr_vec), .cmd_en(cmd_en), .cmd_dis(cmd_dis),
    .cmd_clr(cmd_clr), .cmd_set(cmd_set), .wdata(bus_wdata),
    .ack(ack), .win_id(win_id), .active(active), .enabled(enabled),
    .prio_flat(prio_flat), .sel_prio(sel_prio), .sel_trig(sel_trig),
    .sel_vec(sel_vec), .sel_en(sel_en), .win_vec(win_vec)
  );

  vic_arbiter #(.NSRC(NSRC), .PRIO_W(PRIO_W), .SEL_W(SEL_W)) u_arb (
    .cand(cand), .prio_flat(prio_flat), .found(found),
    .win_id(win_id), .win_prio(win_prio)
  );

  vic_nest_stack #(.DEPTH(NEST_DEPTH), .PRIO_W(PRIO_W), .SEL_W(SEL_W), .CNT_W(CNT_W)) u_stack (
    .clk(clk), .srst_n(srst_n), .push(ack), .pop(eoi),
    .push_prio(win_prio), .push_id(win_id),
    .top_prio(top_prio), .top_id(top_id), .level(stk_level)
  );

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      sel_q  <= '0;
      spur_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (wr_sel)  sel_q  <= bus_wdata[SEL_W-1:0];
      if (wr_spur) spur_q <= bus_wdata[VEC_W-1:0];
      irq_q <= take;
    end
  end
  assign irq_req = irq_q;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFS_SEL:  bus_rdata = 32'(sel_q);
      OFS_MODE: begin
        bus_rdata[PRIO_W-1:0]      = sel_prio;
        bus_rdata[TRG_LSB +: 2]    = sel_trig;
      end
      OFS_VEC:  bus_rdata = 32'(sel_vec);
      OFS_IVEC: bus_rdata = take ? 32'(win_vec) : 32'(spur_q);
      OFS_STAT: if (!stk_empty) bus_rdata = (32'd1 << STAT_VLD) | 32'(top_id);
      OFS_ENA:  bus_rdata = 32'(sel_en);
      OFS_REQ:  bus_rdata = 32'(irq_q);
      OFS_SPUR: bus_rdata = 32'(spur_q);
      default: begin
        if ((bus_addr[7:4] == PEND_HI) && (int'(bus_addr[3:2]) < NWORD))
          bus_rdata = pend_pad[int'(bus_addr[3:2])*32 +: 32];
      end
    endcase
  end
endmodule

// File: rtl/vic_indirect_chk.sv
module vic_indirect_chk #(
  parameter int NSRC       = 128,
  parameter int NEST_DEPTH = 8,
  parameter int CNT_W      = 4
) (
  input logic             clk,
  input logic             srst_n,
  input logic             ack,
  input logic             eoi,
  input logic [CNT_W-1:0] level,
  input logic [NSRC-1:0]  cand,
  input logic             irq_req
);
  assert_nest_bound_R11: assert property (@(posedge clk) disable iff (!srst_n)
    level <= CNT_W'(NEST_DEPTH));

  assert_ack_push_R8: assert property (@(posedge clk) disable iff (!srst_n)
    ack |=> (level == $past(level) + 1'b1));

  assert_eoi_pop_R11: assert property (@(posedge clk) disable iff (!srst_n)
    (eoi && (level != '0)) |=> (level == $past(level) - 1'b1));

  assert_eoi_empty_R11: assert property (@(posedge clk) disable iff (!srst_n)
    (eoi && (level == '0)) |=> (level == '0));

  assert_no_req_when_idle_R4: assert property (@(posedge clk) disable iff (!srst_n)
    (cand == '0) |=> !irq_req);

  assert_req_rise_cause_R13: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(irq_req) |-> $past(|cand));
endmodule

bind vic_indirect vic_indirect_chk #(.NSRC(NSRC), .NEST_DEPTH(NEST_DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .srst_n(srst_n), .ack(ack), .eoi(eoi), .level(stk_level),
  .cand(cand), .irq_req(irq_req)
);

// File: tb/vic_indirect_test.sv
module vic_indirect_test;
  localparam int CLK_PERIOD = 10;
  localparam int N = 128;
  localparam logic [7:0] R_SEL = 8'h00, R_MODE = 8'h04, R_VEC = 8'h08, R_IVEC = 8'h10,
                         R_STAT = 8'h18, R_PW0 = 8'h20, R_PW1 = 8'h24, R_ENA = 8'h30,
                         R_REQ = 8'h34, R_EOI = 8'h38, R_SPUR = 8'h3C, R_EN = 8'h40,
                         R_DIS = 8'h44, R_CLR = 8'h48, R_SET = 8'h4C;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [N-1:0] src_in;
  logic        bus_sel, bus_wr;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        irq_req;
  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vic_indirect uut (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_req(irq_req)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic rd_chk(string req, logic [7:0] a, logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    check(req, d, exp);
  endtask

  task automatic cfg(int s, logic [31:0] mode, logic [31:0] vec);
    wr(R_SEL, s);
    wr(R_MODE, mode);
    wr(R_VEC, vec);
    wr(R_EN, 32'h1);
  endtask

  task automatic t_reset;
    check("R1 irq_req", {31'b0, irq_req}, 0);
    rd_chk("R1 pend w0", R_PW0, 0);
    rd_chk("R1 pend w3", 8'h2C, 0);
    rd_chk("R1 status", R_STAT, 0);
    rd_chk("R1 ivec spurious", R_IVEC, 0);
    rd_chk("R1 status after idle ivec", R_STAT, 0);
    rd_chk("R1 mode", R_MODE, 0);
    rd_chk("R1 enable", R_ENA, 0);
  endtask

  task automatic t_select;
    wr(R_SEL, 32'hFFFF_FF85);
    rd_chk("R2 select low bits", R_SEL, 32'h05);
    wr(R_MODE, 32'hFF);
    rd_chk("R3 mode fields", R_MODE, 32'h67);
    wr(R_VEC, 32'hCAFE_0005);
    wr(R_SEL, 6);
    rd_chk("R2 other mode", R_MODE, 0);
    rd_chk("R2 other vec", R_VEC, 0);
    wr(R_SEL, 5);
    rd_chk("R2 vec back", R_VEC, 32'hCAFE_0005);
    wr(R_MODE, 0);
  endtask

  task automatic t_level;
    cfg(5, 32'h03, 32'h500);
    check("R4 no req before input", {31'b0, irq_req}, 0);
    src_in[5] = 1'b1;
    @(negedge clk);
    check("R13 level one edge", {31'b0, irq_req}, 1);
    rd_chk("R6 pend word0", R_PW0, 32'h20);
    rd_chk("R6 req reg", R_REQ, 1);
    rd_chk("R6 enable reg", R_ENA, 1);
    rd_chk("R8 ivec", R_IVEC, 32'h500);
    @(negedge clk);
    check("R9 req drops after ack", {31'b0, irq_req}, 0);
    rd_chk("R10 status", R_STAT, 32'h105);
    rd_chk("R3 level stays active", R_PW0, 32'h20);
    wr(R_EOI, 0);
    @(negedge clk);
    check("R11 req back after eoi", {31'b0, irq_req}, 1);
    src_in[5] = 1'b0;
    @(negedge clk);
    check("R3 level follows input", {31'b0, irq_req}, 0);
    rd_chk("R3 level inactive", R_PW0, 0);
    wr(R_DIS, 1);
    src_in[5] = 1'b1;
    repeat (2) @(negedge clk);
    check("R4 disabled no req", {31'b0, irq_req}, 0);
    rd_chk("R4 pending visible", R_PW0, 32'h20);
    rd_chk("R4 enable bit off", R_ENA, 0);
    wr(R_EN, 1);
    @(negedge clk);
    check("R4 re-enable req", {31'b0, irq_req}, 1);
    src_in[5] = 1'b0;
    wr(R_DIS, 1);
  endtask

  task automatic t_edge;
    cfg(40, 32'h22, 32'h4000);
    src_in[40] = 1'b1;
    @(negedge clk);
    check("R13 edge not yet", {31'b0, irq_req}, 0);
    @(negedge clk);
    check("R13 edge two edges", {31'b0, irq_req}, 1);
    src_in[40] = 1'b0;
    rd_chk("R3 edge latched", R_PW1, 32'h100);
    rd_chk("R8 ivec edge", R_IVEC, 32'h4000);
    rd_chk("R8 ack clears latch", R_PW1, 0);
    check("R8 req low", {31'b0, irq_req}, 0);
    wr(R_EOI, 0);
    @(negedge clk);
    check("R3 nothing left", {31'b0, irq_req}, 0);
    wr(R_SET, 0);
    rd_chk("R5 set bit0 zero ignored", R_PW1, 0);
    wr(R_SET, 1);
    @(negedge clk);
    check("R5 set raises", {31'b0, irq_req}, 1);
    rd_chk("R5 set pending", R_PW1, 32'h100);
    wr(R_CLR, 1);
    @(negedge clk);
    check("R5 clear drops", {31'b0, irq_req}, 0);
    rd_chk("R5 cleared", R_PW1, 0);
    // falling edge on source 3
    cfg(3, 32'h61, 32'h300);
    src_in[3] = 1'b1;
    repeat (2) @(negedge clk);
    check("R3 fall ignores rise", {31'b0, irq_req}, 0);
    src_in[3] = 1'b0;
    repeat (2) @(negedge clk);
    check("R3 fall latches", {31'b0, irq_req}, 1);
    rd_chk("R8 ivec fall", R_IVEC, 32'h300);
    wr(R_EOI, 0);
    wr(R_SEL, 3);
    wr(R_DIS, 1);
    // level-low on source 4 with input low
    cfg(4, 32'h40, 32'h400);
    rd_chk("R3 level low active", R_PW0, 32'h10);
    check("R3 level low req", {31'b0, irq_req}, 1);
    src_in[4] = 1'b1;
    @(negedge clk);
    check("R3 level low released", {31'b0, irq_req}, 0);
    wr(R_DIS, 1);
  endtask

  task automatic t_prio;
    cfg(10, 32'h22, 32'h0A);  wr(R_SET, 1);
    cfg(71, 32'h26, 32'h47);  wr(R_SET, 1);
    cfg(70, 32'h26, 32'h46);  wr(R_SET, 1);
    rd_chk("R7 tie lowest index", R_IVEC, 32'h46);
    @(negedge clk);
    check("R9 equal prio blocked", {31'b0, irq_req}, 0);
    rd_chk("R10 status 70", R_STAT, 32'h146);
    cfg(100, 32'h27, 32'h64);
    wr(R_SET, 1);
    @(negedge clk);
    check("R9 higher preempts", {31'b0, irq_req}, 1);
    rd_chk("R7 highest wins", R_IVEC, 32'h64);
    rd_chk("R10 status 100", R_STAT, 32'h164);
    wr(R_EOI, 0);
    rd_chk("R11 pop to 70", R_STAT, 32'h146);
    check("R9 still blocked", {31'b0, irq_req}, 0);
    wr(R_EOI, 0);
    @(negedge clk);
    check("R11 empty re-raises", {31'b0, irq_req}, 1);
    rd_chk("R7 next 71", R_IVEC, 32'h47);
    rd_chk("R9 lower nests blocked", R_IVEC, 32'h0);
    wr(R_EOI, 0);
    rd_chk("R7 last 10", R_IVEC, 32'h0A);
    wr(R_EOI, 0);
    @(negedge clk);
    check("R11 all served", {31'b0, irq_req}, 0);
    rd_chk("R10 status empty", R_STAT, 0);
  endtask

  task automatic t_depth;
    for (int k = 0; k < 8; k++) begin
      cfg(16 + k, 32'h20 | k, 32'h1000 + k);
      wr(R_SET, 1);
      rd_chk("R11 fill level", R_IVEC, 32'h1000 + k);
    end
    rd_chk("R10 top of full stack", R_STAT, 32'h117);
    cfg(24, 32'h27, 32'h1018);
    wr(R_SET, 1);
    @(negedge clk);
    check("R9 full stack blocks", {31'b0, irq_req}, 0);
    rd_chk("R12 ivec none spurious", R_IVEC, 0);
    rd_chk("R12 no push", R_STAT, 32'h117);
    for (int k = 0; k < 8; k++) wr(R_EOI, 0);
    rd_chk("R11 eight pops empty", R_STAT, 0);
    check("R11 not locked out", {31'b0, irq_req}, 1);
    rd_chk("R8 ivec after unwind", R_IVEC, 32'h1018);
    wr(R_EOI, 0);
    wr(R_EOI, 0);
    rd_chk("R11 pop on empty", R_STAT, 0);
    wr(R_SEL, 16);
    wr(R_SET, 1);
    @(negedge clk);
    check("R11 prio0 after extra eoi", {31'b0, irq_req}, 1);
    wr(R_CLR, 1);
  endtask

  task automatic t_spur;
    wr(R_SPUR, 32'hDEAD_BEEF);
    rd_chk("R12 spurious reg", R_SPUR, 32'hDEAD_BEEF);
    rd_chk("R12 ivec spurious", R_IVEC, 32'hDEAD_BEEF);
    rd_chk("R12 stack untouched", R_STAT, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    src_in = '0;
    bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset;
    t_select;
    t_level;
    t_edge;
    t_prio;
    t_depth;
    t_spur;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule